// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator with Enable Mask

This block gathers up to sixteen interrupt request lines from board peripherals and presents them to a host processor as a single active-high, level-sensitive interrupt. Each request line is brought into the host clock domain through a flop chain. While the synchronised level is high, the line's bit is set in a sticky pending register. A line contributes to the host interrupt only while its bit in an enable mask is also set. The host removes pending bits by writing ones to them.

The host reaches the block over a simple synchronous register bus with byte addresses. It has a write strobe, a read strobe, 16-bit write data and 16-bit read data. There are four word locations. The pending word is at 0x16, and writing ones to it acknowledges the matching bits. The live word is at 0x18 and shows the synchronised line levels without latching. The enable-set word is at 0x1A, and writing ones to it turns the matching lines on. The enable-clear word is at 0x1C, and writing ones to it turns the matching lines off. A read of either enable word returns the enable mask. Read data is registered, and it is zero in every cycle that does not follow a read of a mapped word.

A typical driver first disables every line and clears every pending bit. It then enables the lines it serves. In its handler it reads the pending word and the enable word, and it acknowledges what it has handled.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the pending word and the enable mask are zero, `irq_o` is low and `bus_rdata_o` is zero.
- R2: A line driven high sets its pending bit on the third rising clock edge after the change, through a two-flop synchroniser. A read of offset 0x18 returns the synchronised levels of all lines, bit n being line n.
- R3: A pending bit stays set after its line falls. Writing 1 to that bit position at offset 0x16 clears it. Writing 0 to a bit position leaves that bit unchanged.
- R4: When a pending bit is being cleared in the same cycle that its synchronised line is high, the bit stays set.
- R5: Writing ones to offset 0x1A sets the matching enable bits, and zero bits in the written word change nothing. A read of 0x1A returns the enable mask.
- R6: Writing ones to offset 0x1C clears the matching enable bits. A read of 0x1C returns the enable mask and changes no state. Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with all lines low, leaves everything disabled and nothing pending.
- R7: `irq_o` is high exactly while some bit is set in both the pending word and the enable mask. It follows the register state in the same cycle.
- R8: A line whose enable bit is clear still sets its pending bit. That bit can be read and acknowledged, and it does not raise `irq_o`.
- R9: A read of any address other than the four mapped offsets returns zero. A write to such an address changes nothing.
- R10: Read data appears on `bus_rdata_o` in the cycle after the read strobe is sampled. In every cycle that does not follow a read, it is zero.
- R11: When a read and a write target the same offset in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 16 | Asynchronous peripheral request lines |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_i | input | 1 | Read strobe, sampled on the rising edge |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Active-high level interrupt to the host |

## Verification
Two events can land on one pending bit in the same cycle: an acknowledge write, and a new event on that bit's line. The bench holds a line high while software writes a one to that bit at 0x16, and it then reads the bit back. The bit must still be set, and it must clear only when an acknowledge arrives after the line has fallen. A read and a write to 0x16 are also issued in one cycle, and the read must return the word as it was before the clear. A behavioural model, advanced on every clock, judges `irq_o` and the read data through both collisions.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;

   // Which register a bus access targets.
   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_PEND  = 3'd1,
      SEL_LIVE  = 3'd2,
      SEL_ENSET = 3'd3,
      SEL_ENCLR = 3'd4
   } reg_sel_e;

   // Full-address compare against the four mapped offsets.
   function automatic reg_sel_e decode_sel(
      input logic [15:0] addr,
      input logic [15:0] pend_ofs,
      input logic [15:0] live_ofs,
      input logic [15:0] enset_ofs,
      input logic [15:0] enclr_ofs
   );
      reg_sel_e sel;
      sel = SEL_NONE;
      if (addr == pend_ofs)       sel = SEL_PEND;
      else if (addr == live_ofs)  sel = SEL_LIVE;
      else if (addr == enset_ofs) sel = SEL_ENSET;
      else if (addr == enclr_ofs) sel = SEL_ENCLR;
      return sel;
   endfunction

endpackage

// File: rtl/irq_fanin_sync.sv
module irq_fanin_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_fanin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_fanin_pending.sv
module irq_fanin_pending #(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);

   logic [WIDTH-1:0] pend_q;

   // Set has priority over an acknowledge in the same cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_i) | set_i;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/irq_fanin_enable.sv
module irq_fanin_enable #(
   parameter int WIDTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] en_o
);

   logic [WIDTH-1:0] en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else begin
         en_q <= (en_q | set_i) & ~clr_i;
      end
   end

   assign en_o = en_q;

endmodule

// File: rtl/irq_fanin_combine.sv
module irq_fanin_combine #(
   parameter int WIDTH   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] pend_i,
   input  logic [WIDTH-1:0] en_i,
   output logic             irq_o
);

   logic any_hit;
   assign any_hit = |(pend_i & en_i);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= any_hit;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_direct
      // Unused in this variant, kept as ports for a uniform interface.
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign irq_o = any_hit;
   end

endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
   import irq_fanin_pkg::*;
#(
   parameter int          NUM_LINES   = 16,
   parameter int          DATA_W      = 16,
   parameter int          ADDR_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter bit          READ_REG    = 1'b1,
   parameter bit          IRQ_REG     = 1'b0,
   parameter logic [15:0] PEND_OFS    = 16'h0016,
   parameter logic [15:0] LIVE_OFS    = 16'h0018,
   parameter logic [15:0] ENSET_OFS   = 16'h001A,
   parameter logic [15:0] ENCLR_OFS   = 16'h001C
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_LINES-1:0] irq_lines_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic                 bus_wr_i,
   input  logic                 bus_rd_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   output logic                 irq_o
);

   localparam int LANES = NUM_LINES;

   // Elaboration-time parameter checks.
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("irq_fanin_ctrl: NUM_LINES must lie in 1..DATA_W");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("irq_fanin_ctrl: ADDR_W must lie in 1..16");
   end
   if (PEND_OFS == LIVE_OFS || PEND_OFS == ENSET_OFS || PEND_OFS == ENCLR_OFS ||
       LIVE_OFS == ENSET_OFS || LIVE_OFS == ENCLR_OFS || ENSET_OFS == ENCLR_OFS) begin : g_bad_map
      $error("irq_fanin_ctrl: register offsets must be distinct");
   end

   logic [LANES-1:0] sync_lvl;
   logic [LANES-1:0] stat_q;
   logic [LANES-1:0] en_q;
   logic [LANES-1:0] wr_lane;
   logic [LANES-1:0] pend_clr;
   logic [LANES-1:0] en_set;
   logic [LANES-1:0] en_clr;
   logic [LANES-1:0] rd_mux;
   logic [DATA_W-1:0] rd_word;
   reg_sel_e         addr_sel;
   reg_sel_e         wr_sel;
   reg_sel_e         rd_sel;

   // Address decode, shared by reads and writes.
   assign addr_sel = decode_sel(16'(bus_addr_i), PEND_OFS, LIVE_OFS, ENSET_OFS, ENCLR_OFS);
   assign wr_sel   = bus_wr_i ? addr_sel : SEL_NONE;
   assign rd_sel   = bus_rd_i ? addr_sel : SEL_NONE;
   assign wr_lane  = bus_wdata_i[LANES-1:0];

   assign pend_clr = (wr_sel == SEL_PEND)  ? wr_lane : '0;
   assign en_set   = (wr_sel == SEL_ENSET) ? wr_lane : '0;
   assign en_clr   = (wr_sel == SEL_ENCLR) ? wr_lane : '0;

   irq_fanin_sync #(
      .WIDTH  (LANES),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (irq_lines_i),
      .q_o    (sync_lvl)
   );

   irq_fanin_pending #(
      .WIDTH  (LANES)
   ) pend_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (sync_lvl),
      .clr_i  (pend_clr),
      .pend_o (stat_q)
   );

   irq_fanin_enable #(
      .WIDTH  (LANES)
   ) en_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (en_set),
      .clr_i  (en_clr),
      .en_o   (en_q)
   );

   irq_fanin_combine #(
      .WIDTH   (LANES),
      .IRQ_REG (IRQ_REG)
   ) comb_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (stat_q),
      .en_i   (en_q),
      .irq_o  (irq_o)
   );

   // Read selection; unmapped or idle cycles give zero.
   always_comb begin
      unique case (rd_sel)
         SEL_PEND:            rd_mux = stat_q;
         SEL_LIVE:            rd_mux = sync_lvl;
         SEL_ENSET, SEL_ENCLR: rd_mux = en_q;
         default:             rd_mux = '0;
      endcase
      rd_word             = '0;
      rd_word[LANES-1:0]  = rd_mux;
   end

   if (READ_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rdata_q <= '0;
         else         rdata_q <= rd_word;
      end
      assign bus_rdata_o = rdata_q;
   end else begin : g_rd_direct
      assign bus_rdata_o = rd_word;
   end

   // Upper write-data bits beyond the line count are not stored.
   if (DATA_W > LANES) begin : g_wr_pad
      logic unused_hi;
      assign unused_hi = |bus_wdata_i[DATA_W-1:LANES];
   end

endmodule

// File: rtl/irq_fanin_chk.sv
module irq_fanin_chk #(
   parameter int          NUM_LINES = 16,
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 8,
   parameter bit          READ_REG  = 1'b1,
   parameter bit          IRQ_REG   = 1'b0,
   parameter logic [15:0] PEND_OFS  = 16'h0016,
   parameter logic [15:0] ENSET_OFS = 16'h001A,
   parameter logic [15:0] ENCLR_OFS = 16'h001C
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 irq_o,
   input logic                 bus_wr_i,
   input logic                 bus_rd_i,
   input logic [ADDR_W-1:0]    bus_addr_i,
   input logic [DATA_W-1:0]    bus_rdata_o,
   input logic [NUM_LINES-1:0] stat_q,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] sync_lvl
);

   logic wr_pend, wr_en;
   assign wr_pend = bus_wr_i && (16'(bus_addr_i) == PEND_OFS);
   assign wr_en   = bus_wr_i && ((16'(bus_addr_i) == ENSET_OFS) || (16'(bus_addr_i) == ENCLR_OFS));

   // R1
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         reset_quiet_chk: assert (!irq_o && bus_rdata_o == '0 && stat_q == '0 && en_q == '0);
      end
   end

   // R3
   pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_pend |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R4
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_lvl != '0) |=> ((stat_q & $past(sync_lvl)) == $past(sync_lvl)));

   // R5
   en_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en |=> $stable(en_q));

   if (IRQ_REG == 1'b0) begin : g_irq_chk
      // R7
      irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((stat_q & en_q) == '0) |-> !irq_o);
      // R8
      irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> ((stat_q & en_q) != '0));
   end

   if (READ_REG) begin : g_rd_chk
      // R10
      rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !bus_rd_i |=> (bus_rdata_o == '0));
   end

endmodule

bind irq_fanin_ctrl irq_fanin_chk #(
   .NUM_LINES (NUM_LINES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .READ_REG  (READ_REG),
   .IRQ_REG   (IRQ_REG),
   .PEND_OFS  (PEND_OFS),
   .ENSET_OFS (ENSET_OFS),
   .ENCLR_OFS (ENCLR_OFS)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .irq_o       (irq_o),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .stat_q      (stat_q),
   .en_q        (en_q),
   .sync_lvl    (sync_lvl)
);

// File: tb/irq_fanin_ctrl_tb_top.sv
module irq_fanin_ctrl_tb_top;

   localparam int CLK_P = 10;
   localparam logic [7:0] A_PEND  = 8'h16;
   localparam logic [7:0] A_LIVE  = 8'h18;
   localparam logic [7:0] A_ENSET = 8'h1A;
   localparam logic [7:0] A_ENCLR = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] lines = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_fanin_ctrl dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .irq_lines_i (lines),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   // Behavioural reference, advanced on every rising edge.
   logic [15:0] m_s1, m_s2, m_pend, m_en, m_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_pend <= '0; m_en <= '0; m_rd <= '0;
      end else begin
         logic [15:0] nxt_en;
         m_s1 <= lines;
         m_s2 <= m_s1;
         m_pend <= ((wr && addr == A_PEND) ? (m_pend & ~wdata) : m_pend) | m_s2;
         nxt_en = m_en;
         if (wr && addr == A_ENSET) nxt_en = nxt_en | wdata;
         if (wr && addr == A_ENCLR) nxt_en = nxt_en & ~wdata;
         m_en <= nxt_en;
         if (!rd)                                   m_rd <= '0;
         else if (addr == A_PEND)                   m_rd <= m_pend;
         else if (addr == A_LIVE)                   m_rd <= m_s2;
         else if (addr == A_ENSET || addr == A_ENCLR) m_rd <= m_en;
         else                                       m_rd <= '0;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the model (R7, R10).
   always @(negedge clk) begin
      if (!done) begin
         check("R7 model irq", {15'd0, irq}, {15'd0, |(m_pend & m_en)});
         check("R10 model rdata", rdata, m_rd);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
      rd = 1'b1; addr = a;
      @(negedge clk);
      d = rdata;
      rd = 1'b0;
   endtask

   initial begin
      logic [15:0] v;
      idle(4);
      // R1 reset state
      check("R1 irq in reset", {15'd0, irq}, 16'h0000);
      check("R1 rdata in reset", rdata, 16'h0000);
      rst_n = 1'b1;
      idle(1);
      rd_reg(A_PEND, v);  check("R1 pending after reset", v, 16'h0000);
      rd_reg(A_ENSET, v); check("R1 enable after reset", v, 16'h0000);

      // R6 init sequence
      wr_reg(A_ENCLR, 16'hFFFF);
      wr_reg(A_PEND, 16'hFFFF);
      rd_reg(A_ENSET, v); check("R6 init enable", v, 16'h0000);
      rd_reg(A_PEND, v);  check("R6 init pending", v, 16'h0000);
      check("R6 init irq", {15'd0, irq}, 16'h0000);

      // R2 latency through the synchroniser
      wr_reg(A_ENSET, 16'h0080);
      lines[7] = 1'b1;
      @(negedge clk); check("R2 edge1 irq", {15'd0, irq}, 16'h0000);
      @(negedge clk); check("R2 edge2 irq", {15'd0, irq}, 16'h0000);
      @(negedge clk); check("R2 edge3 irq", {15'd0, irq}, 16'h0001);

      // R3 sticky, zero-write ignored, one-write clears
      lines[7] = 1'b0;
      idle(4);
      rd_reg(A_PEND, v); check("R3 held", v, 16'h0080);
      check("R3 irq held", {15'd0, irq}, 16'h0001);
      wr_reg(A_PEND, 16'h0000);
      rd_reg(A_PEND, v); check("R3 zero write", v, 16'h0080);
      wr_reg(A_PEND, 16'h0080);
      rd_reg(A_PEND, v); check("R3 ack", v, 16'h0000);
      check("R3 irq after ack", {15'd0, irq}, 16'h0000);

      // R8 masked line still latches
      lines[3] = 1'b1;
      @(negedge clk);
      lines[3] = 1'b0;
      idle(4);
      check("R8 masked no irq", {15'd0, irq}, 16'h0000);
      rd_reg(A_PEND, v); check("R8 masked latched", v, 16'h0008);
      wr_reg(A_PEND, 16'h0008);
      rd_reg(A_PEND, v); check("R8 masked ack", v, 16'h0000);

      // R5 enable set
      wr_reg(A_ENSET, 16'h0300);
      rd_reg(A_ENSET, v); check("R5 set", v, 16'h0380);
      wr_reg(A_ENSET, 16'h0000);
      rd_reg(A_ENSET, v); check("R5 zero set", v, 16'h0380);

      // R6 enable clear and harmless read of clear address
      wr_reg(A_ENCLR, 16'h0100);
      rd_reg(A_ENSET, v); check("R6 cleared", v, 16'h0280);
      rd_reg(A_ENCLR, v); check("R6 read clear addr", v, 16'h0280);
      rd_reg(A_ENSET, v); check("R6 read harmless", v, 16'h0280);

      // R7 output follows pending AND enable
      lines = 16'h0200;
      idle(4);
      check("R7 irq on", {15'd0, irq}, 16'h0001);
      wr_reg(A_ENCLR, 16'h0200);
      check("R7 irq masked", {15'd0, irq}, 16'h0000);
      wr_reg(A_ENSET, 16'h0200);
      check("R7 irq unmasked", {15'd0, irq}, 16'h0001);
      lines = '0;
      idle(3);
      wr_reg(A_PEND, 16'h0200);
      check("R7 irq acked", {15'd0, irq}, 16'h0000);

      // R4 set wins over acknowledge
      lines[5] = 1'b1;
      idle(4);
      wr_reg(A_PEND, 16'h0020);
      rd_reg(A_PEND, v); check("R4 set wins", v, 16'h0020);
      lines[5] = 1'b0;
      idle(4);
      wr_reg(A_PEND, 16'h0020);
      rd_reg(A_PEND, v); check("R4 ack after fall", v, 16'h0000);

      // R2 live view
      lines = 16'hA5A5;
      idle(3);
      rd_reg(A_LIVE, v); check("R2 live pattern", v, 16'hA5A5);
      lines = 16'h0000;
      idle(3);
      rd_reg(A_LIVE, v); check("R2 live low", v, 16'h0000);
      wr_reg(A_PEND, 16'hFFFF);
      rd_reg(A_PEND, v); check("R2 pending cleared", v, 16'h0000);

      // R9 unmapped addresses
      rd_reg(8'h20, v); check("R9 read 0x20", v, 16'h0000);
      rd_reg(8'h17, v); check("R9 read 0x17", v, 16'h0000);
      wr_reg(8'h20, 16'hFFFF);
      wr_reg(8'h1E, 16'hFFFF);
      rd_reg(A_ENSET, v); check("R9 enable untouched", v, 16'h0280);
      rd_reg(A_PEND, v);  check("R9 pending untouched", v, 16'h0000);

      // R10 read latency
      rd = 1'b1; addr = A_ENSET;
      #1 check("R10 before edge", rdata, 16'h0000);
      @(negedge clk);
      check("R10 after edge", rdata, 16'h0280);
      rd = 1'b0;
      @(negedge clk);
      check("R10 back to zero", rdata, 16'h0000);

      // R11 read and write the same offset in one cycle
      lines[1] = 1'b1;
      @(negedge clk);
      lines[1] = 1'b0;
      idle(4);
      rd = 1'b1; wr = 1'b1; addr = A_PEND; wdata = 16'h0002;
      @(negedge clk);
      check("R11 old value read", rdata, 16'h0002);
      rd = 1'b0; wr = 1'b0; wdata = '0;
      rd_reg(A_PEND, v); check("R11 cleared after", v, 16'h0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         done = 1'b1;
         total++;
         fails++;
         $display("FAIL watchdog R1..R11 actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule